// File: doc/BRIEF.md
# Serial Flash Identify and Geometry Probe

This block finds out what kind of buffered serial flash is attached and reports its geometry. The geometry is the number of pages, the page size in bytes, the shift that places the page number inside a device address, and a flag telling whether the part is working with power-of-two pages. The block starts one probe by itself as it leaves reset. It starts another whenever `start` is pulsed while it is idle.

A probe first issues the 0x9F identification command and reads three bytes: a manufacturer byte, then two device bytes. When the manufacturer byte is 0x1F, the two device bytes are looked up in a fixed internal table. Parts that can run with either page size then get a status read (0xD7), and bit 0 of that status selects the power-of-two geometry. When the manufacturer byte is anything else, the block falls back to a status read alone and decodes a density code from status bits [5:2].

The block drives a byte-level transfer port. It asks for one byte at a time and marks the last byte of each command so that the shifter can release chip select. Shifting the bits themselves is left to the attached shifter.

Top module: `flash_geom_probe`

## Requirements
- R1: One cycle after reset is released, a probe starts with no `start` pulse, and its first byte is the identification opcode 0x9F.
- R2: The identification command is a frame of four bytes: the opcode, then three bytes sent as 0x00 whose replies are taken as manufacturer, device-high and device-low. `xfer_end` is set on the fourth byte only.
- R3: When the manufacturer reply is not 0x1F, exactly one more frame follows. It is two bytes long: opcode 0xD7, then one 0x00 byte whose reply is the status. `geo_jedec` is then 0.
- R4: In the fallback path, a status of 0x00 or 0xFF reports `geo_err` = 1 (no device), with pages, bytes, shift and `geo_pow2` all zero.
- R5: In the fallback path, status AND 0x3C decodes as follows:
  - 0x0C gives 512 pages of 264 bytes, shift 9.
  - 0x14 gives 1024 pages of 264 bytes, shift 9.
  - 0x1C gives 2048 pages of 264 bytes, shift 9.
  - 0x24 gives 4096 pages of 264 bytes, shift 9.
  - 0x2C gives 4096 pages of 528 bytes, shift 10.
  - 0x34 gives 8192 pages of 528 bytes, shift 10.
  - 0x38 and 0x3C give 8192 pages of 1056 bytes, shift 11.
  
  Each of these reports `geo_err` = 0.
- R6: Any other fallback code, other than the no-device values of R4, reports `geo_err` = 2 (unsupported) with zero geometry.
- R7: With manufacturer 0x1F, device bytes 0x22 to 0x28 followed by 0x00 are known parts. They map in order onto the seven geometries of R5. Device 0x2701 is also known and has the geometry of 0x2700. Every known part reports `geo_jedec` = 1 and `geo_err` = 0. Device 0x2700 has no binary option, so no status frame is sent for it.
- R8: Every other known part gets a 0xD7 status frame after the identification frame. When status bit 0 is 1, the page size becomes 2 to the power (shift − 1), the shift drops by one and `geo_pow2` = 1. When status bit 0 is 0, the table geometry is reported with `geo_pow2` = 0.
- R9: With manufacturer 0x1F and device bytes not in the table, the block reports `geo_err` = 2 with `geo_jedec` = 0, and sends no further frame.
- R10: Each probe ends with `geo_valid` high for exactly one cycle. The result outputs change only in that cycle and hold their values until the next probe ends.
- R11: `busy` is high from the cycle after a probe is accepted until `geo_valid`. A `start` pulse while `busy` is high is ignored: no extra frame and no extra `geo_valid`.
- R12: At most one byte request is in flight. `xfer_req` is a one-cycle pulse followed by a wait for `xfer_done`. `xfer_end` is high only together with `xfer_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new probe (taken only while idle) |
| xfer_req | output | 1 | One-cycle request to shift one byte |
| xfer_tx | output | 8 | Byte to send |
| xfer_end | output | 1 | This byte is the last of the frame; release chip select after it |
| xfer_done | input | 1 | Shifter finished the requested byte |
| xfer_rx | input | 8 | Byte received during the finished transfer |
| busy | output | 1 | Probe in progress |
| geo_valid | output | 1 | One-cycle strobe: results are new |
| geo_err | output | 2 | 0 ok, 1 no device, 2 unsupported device |
| geo_jedec | output | 1 | Set when the part was recognised through its identification bytes |
| geo_pow2 | output | 1 | Part runs with power-of-two pages |
| geo_pages | output | PAGES_W | Number of pages |
| geo_bytes | output | BYTES_W | Bytes per page |
| geo_shift | output | SHIFT_W | Bit position of the page number in a device address |

## Verification
The bench builds the block with its default parameters:
- manufacturer code 0x1F;
- first density byte 0x22;
- the split entry at 0x27;
- automatic start enabled;
- 16-bit page count, 11-bit byte count and 4-bit shift outputs.

With these values the full fallback space is small enough to cover completely. A behavioural shifter with a fixed two-cycle reply delay serves every one of the 256 status values, and also sweeps device bytes 0x20 to 0x29 against low bytes 0x00 to 0x02, each with status bit 0 both clear and set. This reaches:
- every table entry;
- the split entry with and without its binary option;
- the neighbouring unknown identifiers on both sides of the table.

// File: rtl/fgp_pkg.sv
package fgp_pkg;

   typedef enum logic [1:0] {
      FGP_OK    = 2'd0,
      FGP_NODEV = 2'd1,
      FGP_UNSUP = 2'd2
   } fgp_err_e;

   localparam int unsigned FGP_DENS_N = 7;
   localparam int unsigned FGP_PG_W   = 14;
   localparam int unsigned FGP_BY_W   = 11;
   localparam int unsigned FGP_SH_W   = 4;

   typedef struct packed {
      logic [FGP_PG_W-1:0] pages;
      logic [FGP_BY_W-1:0] bytes;
      logic [FGP_SH_W-1:0] shift;
   } fgp_geom_t;

   // Density index 0..6 -> non-binary geometry, computed rather than tabulated
   function automatic fgp_geom_t fgp_geom_of(input logic [2:0] d);
      fgp_geom_t g;
      if (d <= 3'd3) begin
         g.pages = FGP_PG_W'(14'd512 << d);
         g.bytes = 11'd264;
         g.shift = 4'd9;
      end else if (d <= 3'd5) begin
         g.pages = (d == 3'd4) ? 14'd4096 : 14'd8192;
         g.bytes = 11'd528;
         g.shift = 4'd10;
      end else begin
         g.pages = 14'd8192;
         g.bytes = 11'd1056;
         g.shift = 4'd11;
      end
      return g;
   endfunction

   // Binary variant: same page count, 2^(shift-1) bytes, shift one smaller
   function automatic fgp_geom_t fgp_to_pow2(input fgp_geom_t g);
      fgp_geom_t b;
      b.pages = g.pages;
      b.shift = g.shift - 4'd1;
      b.bytes = FGP_BY_W'(11'd1 << b.shift);
      return b;
   endfunction

endpackage

// File: rtl/fgp_frame_engine.sv
module fgp_frame_engine #(
   parameter int unsigned MAX_RD = 3,
   localparam int unsigned IDX_W = $clog2(MAX_RD + 1),
   localparam int unsigned CAP_W = 8 * MAX_RD
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [7:0]       op,
   input  logic [IDX_W-1:0] nrd,
   output logic             fdone,
   output logic [CAP_W-1:0] cap,
   output logic             xfer_req,
   output logic [7:0]       xfer_tx,
   output logic             xfer_end,
   input  logic             xfer_done,
   input  logic [7:0]       xfer_rx
);

   typedef enum logic [1:0] {FE_IDLE, FE_ISSUE, FE_WAIT} fe_state_e;

   fe_state_e        st;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] lim;
   logic [7:0]       op_q;

   initial begin : elab_chk
      assert (MAX_RD >= 1) else $error("MAX_RD must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= FE_IDLE;
         idx   <= '0;
         lim   <= '0;
         op_q  <= '0;
         cap   <= '0;
         fdone <= 1'b0;
      end else begin
         fdone <= 1'b0;
         case (st)
            FE_IDLE: begin
               if (go) begin
                  op_q <= op;
                  lim  <= nrd;
                  idx  <= '0;
                  st   <= FE_ISSUE;
               end
            end
            FE_ISSUE: st <= FE_WAIT;
            FE_WAIT: begin
               if (xfer_done) begin
                  if (idx != '0) begin
                     if (CAP_W > 8) cap <= {cap[CAP_W-9:0], xfer_rx};
                     else           cap <= CAP_W'(xfer_rx);
                  end
                  if (idx == lim) begin
                     fdone <= 1'b1;
                     st    <= FE_IDLE;
                  end else begin
                     idx <= idx + 1'b1;
                     st  <= FE_ISSUE;
                  end
               end
            end
            default: st <= FE_IDLE;
         endcase
      end
   end

   always_comb begin
      xfer_req = (st == FE_ISSUE);
      xfer_tx  = (idx == '0) ? op_q : 8'h00;
      xfer_end = xfer_req && (idx == lim);
   end

endmodule

// File: rtl/fgp_id_lookup.sv
module fgp_id_lookup #(
   parameter logic [7:0] DENS_BASE = 8'h22,
   parameter logic [7:0] SPLIT_ID  = 8'h27
) (
   input  logic [7:0] id_hi,
   input  logic [7:0] id_lo,
   output logic       hit,
   output logic [2:0] dens,
   output logic       bin_cap
);
   import fgp_pkg::*;

   logic [7:0] off;
   logic       in_rng;

   initial begin : elab_chk
      assert (SPLIT_ID >= DENS_BASE && (SPLIT_ID - DENS_BASE) < FGP_DENS_N)
         else $error("SPLIT_ID outside the density range");
   end

   always_comb begin
      off     = id_hi - DENS_BASE;
      in_rng  = (id_hi >= DENS_BASE) && (off < 8'(FGP_DENS_N));
      dens    = off[2:0];
      if (id_hi == SPLIT_ID) begin
         hit     = (id_lo == 8'h00) || (id_lo == 8'h01);
         bin_cap = (id_lo == 8'h01);
      end else begin
         hit     = in_rng && (id_lo == 8'h00);
         bin_cap = 1'b1;
      end
   end

endmodule

// File: rtl/fgp_status_decode.sv
module fgp_status_decode #(
   parameter int unsigned CODE_LSB = 2,
   parameter int unsigned CODE_W   = 4,
   localparam int unsigned CODE_N  = 1 << CODE_W
) (
   input  logic [7:0] status,
   output logic       absent,
   output logic       hit,
   output logic [2:0] dens
);

   logic [CODE_N-1:0] code_ok;
   logic [2:0]        code_dens [CODE_N];
   logic [CODE_W-1:0] code;

   initial begin : elab_chk
      assert (CODE_LSB + CODE_W <= 8) else $error("status code field exceeds one byte");
   end

   // Codes 3,5,..,13 step through densities 0..5; 14 and 15 share density 6
   for (genvar c = 0; c < CODE_N; c++) begin : g_code
      localparam int CV = c;
      assign code_ok[c]   = (CV >= 14) || ((CV % 2 == 1) && CV >= 3 && CV <= 13);
      assign code_dens[c] = (CV >= 14) ? 3'd6 : ((CV >= 3) ? 3'((CV - 3) / 2) : 3'd0);
   end

   always_comb begin
      code   = status[CODE_LSB +: CODE_W];
      absent = (status == 8'h00) || (status == 8'hFF);
      hit    = !absent && code_ok[code];
      dens   = code_dens[code];
   end

endmodule

// File: rtl/flash_geom_probe.sv
module flash_geom_probe
   import fgp_pkg::*;
#(
   parameter logic [7:0]  MFR_CODE   = 8'h1F,
   parameter logic [7:0]  ID_OP      = 8'h9F,
   parameter logic [7:0]  STAT_OP    = 8'hD7,
   parameter logic [7:0]  DENS_BASE  = 8'h22,
   parameter logic [7:0]  SPLIT_ID   = 8'h27,
   parameter bit          AUTO_START = 1'b1,
   parameter int unsigned PAGES_W    = 16,
   parameter int unsigned BYTES_W    = 11,
   parameter int unsigned SHIFT_W    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic               xfer_req,
   output logic [7:0]         xfer_tx,
   output logic               xfer_end,
   input  logic               xfer_done,
   input  logic [7:0]         xfer_rx,
   output logic               busy,
   output logic               geo_valid,
   output logic [1:0]         geo_err,
   output logic               geo_jedec,
   output logic               geo_pow2,
   output logic [PAGES_W-1:0] geo_pages,
   output logic [BYTES_W-1:0] geo_bytes,
   output logic [SHIFT_W-1:0] geo_shift
);

   localparam int unsigned ID_BYTES = 3;
   localparam int unsigned IDX_W    = $clog2(ID_BYTES + 1);
   localparam int unsigned CAP_W    = 8 * ID_BYTES;

   initial begin : elab_chk
      assert (PAGES_W >= FGP_PG_W) else $error("PAGES_W too narrow");
      assert (BYTES_W >= FGP_BY_W) else $error("BYTES_W too narrow");
      assert (SHIFT_W >= FGP_SH_W) else $error("SHIFT_W too narrow");
   end

   typedef enum logic [1:0] {S_IDLE, S_ID, S_FB, S_MODE} sq_state_e;

   sq_state_e        st;
   logic             fe_go;
   logic [7:0]       fe_op;
   logic [IDX_W-1:0] fe_nrd;
   logic             fe_done;
   logic [CAP_W-1:0] fe_cap;
   logic             kick;
   logic             launch;

   logic             id_hit, id_bin;
   logic [2:0]       id_dens;
   logic             sd_absent, sd_hit;
   logic [2:0]       sd_dens;
   logic [2:0]       dens_q;

   fgp_err_e         r_err;
   logic             r_jedec, r_pow2;
   fgp_geom_t        r_geom;

   // Power-on request: either a one-shot after reset or nothing
   if (AUTO_START) begin : g_auto
      always_ff @(posedge clk) begin
         if (!rst_n) kick <= 1'b1;
         else        kick <= 1'b0;
      end
   end else begin : g_manual
      assign kick = 1'b0;
   end

   assign launch = start || kick;

   fgp_frame_engine #(.MAX_RD(ID_BYTES)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (fe_go),
      .op       (fe_op),
      .nrd      (fe_nrd),
      .fdone    (fe_done),
      .cap      (fe_cap),
      .xfer_req (xfer_req),
      .xfer_tx  (xfer_tx),
      .xfer_end (xfer_end),
      .xfer_done(xfer_done),
      .xfer_rx  (xfer_rx)
   );

   fgp_id_lookup #(.DENS_BASE(DENS_BASE), .SPLIT_ID(SPLIT_ID)) u_idlut (
      .id_hi  (fe_cap[15:8]),
      .id_lo  (fe_cap[7:0]),
      .hit    (id_hit),
      .dens   (id_dens),
      .bin_cap(id_bin)
   );

   fgp_status_decode u_sdec (
      .status(fe_cap[7:0]),
      .absent(sd_absent),
      .hit   (sd_hit),
      .dens  (sd_dens)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         fe_go     <= 1'b0;
         fe_op     <= '0;
         fe_nrd    <= '0;
         dens_q    <= '0;
         r_err     <= FGP_OK;
         r_jedec   <= 1'b0;
         r_pow2    <= 1'b0;
         r_geom    <= '0;
         geo_valid <= 1'b0;
      end else begin
         fe_go     <= 1'b0;
         geo_valid <= 1'b0;
         case (st)
            S_IDLE: begin
               if (launch) begin
                  fe_go  <= 1'b1;
                  fe_op  <= ID_OP;
                  fe_nrd <= IDX_W'(ID_BYTES);
                  st     <= S_ID;
               end
            end
            S_ID: begin
               if (fe_done) begin
                  if (fe_cap[23:16] != MFR_CODE) begin
                     fe_go  <= 1'b1;
                     fe_op  <= STAT_OP;
                     fe_nrd <= IDX_W'(1);
                     st     <= S_FB;
                  end else if (!id_hit) begin
                     r_err     <= FGP_UNSUP;
                     r_jedec   <= 1'b0;
                     r_pow2    <= 1'b0;
                     r_geom    <= '0;
                     geo_valid <= 1'b1;
                     st        <= S_IDLE;
                  end else if (id_bin) begin
                     dens_q <= id_dens;
                     fe_go  <= 1'b1;
                     fe_op  <= STAT_OP;
                     fe_nrd <= IDX_W'(1);
                     st     <= S_MODE;
                  end else begin
                     r_err     <= FGP_OK;
                     r_jedec   <= 1'b1;
                     r_pow2    <= 1'b0;
                     r_geom    <= fgp_geom_of(id_dens);
                     geo_valid <= 1'b1;
                     st        <= S_IDLE;
                  end
               end
            end
            S_FB: begin
               if (fe_done) begin
                  r_jedec   <= 1'b0;
                  r_pow2    <= 1'b0;
                  geo_valid <= 1'b1;
                  st        <= S_IDLE;
                  if (sd_absent) begin
                     r_err  <= FGP_NODEV;
                     r_geom <= '0;
                  end else if (!sd_hit) begin
                     r_err  <= FGP_UNSUP;
                     r_geom <= '0;
                  end else begin
                     r_err  <= FGP_OK;
                     r_geom <= fgp_geom_of(sd_dens);
                  end
               end
            end
            S_MODE: begin
               if (fe_done) begin
                  r_err     <= FGP_OK;
                  r_jedec   <= 1'b1;
                  r_pow2    <= fe_cap[0];
                  r_geom    <= fe_cap[0] ? fgp_to_pow2(fgp_geom_of(dens_q))
                                         : fgp_geom_of(dens_q);
                  geo_valid <= 1'b1;
                  st        <= S_IDLE;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      busy      = (st != S_IDLE);
      geo_err   = r_err;
      geo_jedec = r_jedec;
      geo_pow2  = r_pow2;
      geo_pages = PAGES_W'(r_geom.pages);
      geo_bytes = BYTES_W'(r_geom.bytes);
      geo_shift = SHIFT_W'(r_geom.shift);
   end

endmodule

// File: rtl/fgp_chk.sv
module fgp_chk #(
   parameter int unsigned PAGES_W = 16,
   parameter int unsigned BYTES_W = 11,
   parameter int unsigned SHIFT_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               xfer_req,
   input logic               xfer_end,
   input logic               busy,
   input logic               geo_valid,
   input logic [1:0]         geo_err,
   input logic               geo_jedec,
   input logic               geo_pow2,
   input logic [PAGES_W-1:0] geo_pages,
   input logic [BYTES_W-1:0] geo_bytes,
   input logic [SHIFT_W-1:0] geo_shift
);

   // R10
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      geo_valid |=> !geo_valid);

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !geo_valid |-> ($stable(geo_pages) && $stable(geo_bytes) && $stable(geo_shift)
                      && $stable(geo_err) && $stable(geo_pow2) && $stable(geo_jedec)));

   // R12
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |=> !xfer_req);

   // R12
   end_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end |-> xfer_req);

   // R11
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> busy);

   // R11
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy && !geo_valid) |=> busy || geo_valid);

   // R4
   nodev_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (geo_valid && geo_err == 2'd1) |-> (geo_pages == '0 && geo_bytes == '0 && !geo_pow2));

   // R8
   pow2_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (geo_valid && geo_pow2) |-> (geo_bytes == (BYTES_W'(1) << geo_shift)));

   // R9
   err_no_jedec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (geo_valid && geo_err != 2'd0) |-> !geo_jedec);

endmodule

bind flash_geom_probe fgp_chk #(
   .PAGES_W(PAGES_W),
   .BYTES_W(BYTES_W),
   .SHIFT_W(SHIFT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .xfer_req (xfer_req),
   .xfer_end (xfer_end),
   .busy     (busy),
   .geo_valid(geo_valid),
   .geo_err  (geo_err),
   .geo_jedec(geo_jedec),
   .geo_pow2 (geo_pow2),
   .geo_pages(geo_pages),
   .geo_bytes(geo_bytes),
   .geo_shift(geo_shift)
);

// File: tb/flash_geom_probe_tb.sv
`timescale 1ns/1ps
module flash_geom_probe_tb;

   localparam int DLY = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        xfer_req, xfer_end, busy, geo_valid, geo_jedec, geo_pow2;
   logic [7:0]  xfer_tx;
   logic        xfer_done = 1'b0;
   logic [7:0]  xfer_rx = 8'h00;
   logic [1:0]  geo_err;
   logic [15:0] geo_pages;
   logic [10:0] geo_bytes;
   logic [3:0]  geo_shift;

   always #5 clk = ~clk;

   flash_geom_probe u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_end(xfer_end),
      .xfer_done(xfer_done), .xfer_rx(xfer_rx),
      .busy(busy), .geo_valid(geo_valid), .geo_err(geo_err),
      .geo_jedec(geo_jedec), .geo_pow2(geo_pow2),
      .geo_pages(geo_pages), .geo_bytes(geo_bytes), .geo_shift(geo_shift)
   );

   // Flash model settings (written by the stimulus only)
   logic [7:0] m_mfr = 8'h1F, m_i1 = 8'h26, m_i2 = 8'h00, m_st = 8'h01;

   // Flash / shifter model
   int         pend = 0, bidx = 0, ftot = 0, dummy_bad = 0, overlap = 0, vcnt = 0;
   logic [7:0] cur_op = 8'h00, rsp = 8'h00;
   int         ops [8];
   int         flen [8];

   always @(posedge clk) begin
      xfer_done <= 1'b0;
      if (!rst_n) begin
         pend <= 0;
         bidx <= 0;
      end else if (xfer_req) begin
         if (pend != 0) overlap <= overlap + 1;
         if (bidx == 0) begin
            ops[ftot % 8] <= int'(xfer_tx);
            cur_op <= xfer_tx;
            rsp    <= 8'hFF;
         end else begin
            if (xfer_tx != 8'h00) dummy_bad <= dummy_bad + 1;
            if (cur_op == 8'h9F)
               rsp <= (bidx == 1) ? m_mfr : (bidx == 2) ? m_i1 : (bidx == 3) ? m_i2 : 8'h00;
            else if (cur_op == 8'hD7)
               rsp <= m_st;
            else
               rsp <= 8'hFF;
         end
         if (xfer_end) begin
            flen[ftot % 8] <= bidx + 1;
            ftot <= ftot + 1;
            bidx <= 0;
         end else begin
            bidx <= bidx + 1;
         end
         pend <= DLY;
      end else if (pend != 0) begin
         pend <= pend - 1;
         if (pend == 1) begin
            xfer_done <= 1'b1;
            xfer_rx   <= rsp;
         end
      end
   end

   always @(posedge clk) if (geo_valid) vcnt <= vcnt + 1;

   int ncmp = 0, nbad = 0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      ncmp++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Expected result from the requirement tables
   task automatic expect_of(input logic [7:0] mfr, i1, i2, st,
                            output int e_err, e_pg, e_by, e_sh, e_p2, e_jd, e_nfr,
                            output string tag);
      bit bin;
      e_err = 0; e_pg = 0; e_by = 0; e_sh = 0; e_p2 = 0; e_jd = 0; bin = 0;
      if (mfr != 8'h1F) begin
         e_nfr = 2;
         if (st == 8'h00 || st == 8'hFF) begin
            e_err = 1; tag = "R4";
         end else begin
            tag = "R5";
            case (st & 8'h3C)
               8'h0C: begin e_pg = 512;  e_by = 264;  e_sh = 9;  end
               8'h14: begin e_pg = 1024; e_by = 264;  e_sh = 9;  end
               8'h1C: begin e_pg = 2048; e_by = 264;  e_sh = 9;  end
               8'h24: begin e_pg = 4096; e_by = 264;  e_sh = 9;  end
               8'h2C: begin e_pg = 4096; e_by = 528;  e_sh = 10; end
               8'h34: begin e_pg = 8192; e_by = 528;  e_sh = 10; end
               8'h38, 8'h3C: begin e_pg = 8192; e_by = 1056; e_sh = 11; end
               default: begin e_err = 2; tag = "R6"; end
            endcase
         end
      end else begin
         e_nfr = 1;
         tag = "R7";
         case ({i1, i2})
            16'h2200: begin e_pg = 512;  e_by = 264;  e_sh = 9;  bin = 1; end
            16'h2300: begin e_pg = 1024; e_by = 264;  e_sh = 9;  bin = 1; end
            16'h2400: begin e_pg = 2048; e_by = 264;  e_sh = 9;  bin = 1; end
            16'h2500: begin e_pg = 4096; e_by = 264;  e_sh = 9;  bin = 1; end
            16'h2600: begin e_pg = 4096; e_by = 528;  e_sh = 10; bin = 1; end
            16'h2700: begin e_pg = 8192; e_by = 528;  e_sh = 10; bin = 0; end
            16'h2701: begin e_pg = 8192; e_by = 528;  e_sh = 10; bin = 1; end
            16'h2800: begin e_pg = 8192; e_by = 1056; e_sh = 11; bin = 1; end
            default: begin e_err = 2; tag = "R9"; end
         endcase
         if (e_err == 0) begin
            e_jd = 1;
            if (bin) begin
               e_nfr = 2;
               tag = "R8";
               if (st[0]) begin
                  e_by = e_by - e_by / 33;
                  e_sh = e_sh - 1;
                  e_p2 = 1;
               end
            end
         end
      end
   endtask

   task automatic probe(input logic [7:0] mfr, i1, i2, st, input bit use_start);
      int e_err, e_pg, e_by, e_sh, e_p2, e_jd, e_nfr, base, vb, t;
      string tag;
      expect_of(mfr, i1, i2, st, e_err, e_pg, e_by, e_sh, e_p2, e_jd, e_nfr, tag);
      m_mfr = mfr; m_i1 = i1; m_i2 = i2; m_st = st;
      base = ftot;
      vb = vcnt;
      if (use_start) begin
         @(negedge clk); start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      t = 0;
      while (!geo_valid && t < 400) begin @(negedge clk); t++; end
      chk("R10", "valid seen", int'(geo_valid), 1);
      chk(tag, "err", int'(geo_err), e_err);
      chk(tag, "pages", int'(geo_pages), e_pg);
      chk(tag, "bytes", int'(geo_bytes), e_by);
      chk(tag, "shift", int'(geo_shift), e_sh);
      chk(tag, "pow2", int'(geo_pow2), e_p2);
      chk(tag, "jedec", int'(geo_jedec), e_jd);
      chk(tag, "frames", ftot - base, e_nfr);
      chk("R2", "id opcode", ops[base % 8], 8'h9F);
      chk("R2", "id frame len", flen[base % 8], 4);
      if (e_nfr == 2) begin
         chk("R3", "status opcode", ops[(base + 1) % 8], 8'hD7);
         chk("R3", "status frame len", flen[(base + 1) % 8], 2);
      end
      @(negedge clk);
      chk("R10", "valid pulse width", int'(geo_valid), 0);
      chk("R10", "one valid", vcnt - vb, 1);
   endtask

   initial begin
      fork
         begin : main_seq
            int base, vb;
            // Reset state
            repeat (3) @(negedge clk);
            chk("R10", "reset valid", int'(geo_valid), 0);
            chk("R11", "reset busy", int'(busy), 0);
            chk("R12", "reset req", int'(xfer_req), 0);
            chk("R10", "reset err", int'(geo_err), 0);
            // R1: automatic probe after reset, model preset to 0x1F2600 binary
            rst_n = 1'b1;
            probe(8'h1F, 8'h26, 8'h00, 8'h01, 1'b0);
            chk("R1", "auto probe pages", int'(geo_pages), 4096);
            chk("R1", "auto probe bytes", int'(geo_bytes), 512);
            // R3..R6: full fallback sweep
            for (int s = 0; s < 256; s++) probe(8'h00, 8'h26, 8'h00, 8'(s), 1'b1);
            probe(8'h1E, 8'h22, 8'h00, 8'h0C, 1'b1);
            probe(8'h9F, 8'h22, 8'h00, 8'h3B, 1'b1);
            probe(8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b1);
            // R7..R9: identification neighbourhood sweep
            for (int a = 8'h20; a <= 8'h29; a++)
               for (int b = 0; b < 3; b++) begin
                  probe(8'h1F, 8'(a), 8'(b), 8'hA4, 1'b1);
                  probe(8'h1F, 8'(a), 8'(b), 8'hA5, 1'b1);
               end
            // R11: start while busy is ignored
            m_mfr = 8'h00; m_st = 8'h2C;
            base = ftot; vb = vcnt;
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            chk("R11", "busy after start", int'(busy), 1);
            repeat (4) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (80) @(negedge clk);
            chk("R11", "valid count", vcnt - vb, 1);
            chk("R11", "frame count", ftot - base, 2);
            chk("R11", "idle after", int'(busy), 0);
            chk("R11", "pages", int'(geo_pages), 4096);
            // R12: one byte in flight, dummy bytes zero
            chk("R12", "overlapping requests", overlap, 0);
            chk("R2", "nonzero dummy bytes", dummy_bad, 0);
         end
         begin : watchdog
            repeat (150000) @(posedge clk);
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
   end

endmodule